// File: doc/BRIEF.md
# Programmable Flag Offset Loader

This block holds the two threshold offsets used by a FIFO's programmable flags. One offset sets the almost-empty threshold and the other sets the almost-full threshold. The flag comparators sit outside this block and compare the FIFO occupancy against these two values. The offset width equals the address width of the FIFO depth.

While master reset is held, two things happen on each write-clock edge. A configuration input picks one of two preset default values, and that value is loaded into both offsets. The shared serial/mode pin is also sampled and kept as the timing-mode select. After reset the offsets can be rewritten in two ways:
- In parallel from the low bits of the data bus, one whole offset per strobed write.
- Serially, one bit per write clock, through the same shared pin.

Either offset can be read back in parallel on the read clock. Partial reset restarts the load and read-back sequences but keeps the offset values.

Read-back is a pull interface. Each strobed read produces one result, and `rd_valid` marks that result for exactly one read-clock cycle. There is no back-pressure path: the consumer paces read-back through its own strobes, so no ready signal exists. Both resets must be synchronous to both clocks. The offsets must be static while a read-back is in progress.

Top module: `flag_ofs_loader`

## Requirements
- R1: While `mrst` is high at a write-clock edge, both offsets load DFLT_A (default 7) when `dflt_sel` is 0, or DFLT_B (default 63) when `dflt_sel` is 1.
- R2: `timing_mode` takes the value of `ser_in_mode` at each write-clock edge with `mrst` high, and holds that value at every other edge.
- R3: A write-clock edge with `ld` and `wr_en` high writes `din[AW-1:0]` into the next offset in the order almost-empty, almost-full, almost-empty and so on, starting at almost-empty after either reset.
- R4: A write-clock edge with `ser_en` high and no parallel write stores `ser_in_mode` into the next serial bit position. Positions 0..AW-1 are almost-empty bits 0..AW-1, with the LSB first. Positions AW..2*AW-1 are almost-full bits 0..AW-1. After the last position the next bit goes back to position 0.
- R5: When a parallel write and `ser_en` occur on the same edge, only the parallel write takes effect, and the serial bit position does not advance.
- R6: `prst` changes neither offset. It sends the parallel write sequence, the serial bit position and the read-back sequence back to the almost-empty start.
- R7: A read-clock edge with `ld` and `rd_en` high makes `rd_valid` high for the next cycle. In that cycle `rd_data` holds the next offset, zero-extended to DW bits, in the same alternating order as R3.
- R8: `wr_en` without `ld` and without `ser_en` changes no offset. `rd_en` without `ld` produces no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock: loads, serial shifts, reset capture |
| rd_clk | input | 1 | Read clock: read-back |
| mrst | input | 1 | Master reset, active high, synchronous |
| prst | input | 1 | Partial reset, active high, synchronous |
| dflt_sel | input | 1 | Chooses the default offset pair during master reset |
| ld | input | 1 | Offset access strobe for parallel write and read-back |
| wr_en | input | 1 | Write enable |
| rd_en | input | 1 | Read enable |
| ser_en | input | 1 | Serial shift enable |
| ser_in_mode | input | 1 | Serial data after reset; timing-mode select during master reset |
| din | input | DW | Data bus; the low AW bits carry a parallel offset |
| ae_off | output | AW | Almost-empty offset |
| af_off | output | AW | Almost-full offset |
| timing_mode | output | 1 | Timing mode captured at master reset |
| rd_data | output | DW | Read-back offset, zero-extended |
| rd_valid | output | 1 | Marks `rd_data` for one read-clock cycle |

## Verification
The assertions check these rules on every cycle:
- Offsets stay unchanged through partial reset and through cycles with no load or shift strobe.
- A parallel write lands in one of the two offsets.
- The captured timing mode stays still outside master reset.
- `rd_valid` appears exactly one cycle after a read strobe and never without one.

Other behaviour needs the bench's scenarios:
- The alternating almost-empty/almost-full order and its wrap.
- The LSB-first bit placement across both serial registers.
- The priority of a parallel write over a serial shift.
- The sequence restart after partial reset.
- The choice between the two default pairs.

// File: rtl/flag_ofs_pkg.sv
`timescale 1ns/1ps
package flag_ofs_pkg;
  typedef enum logic {
    SEL_AE = 1'b0,
    SEL_AF = 1'b1
  } ofs_sel_e;

  function automatic ofs_sel_e next_sel(input ofs_sel_e cur);
    return (cur == SEL_AE) ? SEL_AF : SEL_AE;
  endfunction
endpackage

// File: rtl/ofs_seq_ptr.sv
`timescale 1ns/1ps
module ofs_seq_ptr
  import flag_ofs_pkg::*;
(
  input  logic     clk,
  input  logic     clr,
  input  logic     adv,
  output ofs_sel_e sel
);
  always_ff @(posedge clk) begin
    if (clr)      sel <= SEL_AE;
    else if (adv) sel <= next_sel(sel);
  end
endmodule

// File: rtl/ofs_store.sv
`timescale 1ns/1ps
module ofs_store
  import flag_ofs_pkg::*;
#(
  parameter int AW     = 10,
  parameter int DW     = 18,
  parameter int DFLT_A = 7,
  parameter int DFLT_B = 63
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          dflt_sel,
  input  logic          par_wr,
  input  logic          sen,
  input  logic          si,
  input  ofs_sel_e      wr_sel,
  input  logic [DW-1:0] din,
  output logic [AW-1:0] ae_q,
  output logic [AW-1:0] af_q,
  output logic          mode_q
);
  localparam int NBITS = 2 * AW;
  localparam int IW    = $clog2(NBITS);
  localparam logic [IW-1:0] LAST = IW'(NBITS - 1);

  logic [IW-1:0] bit_idx;

  always_ff @(posedge clk) begin
    if (mrst) begin
      ae_q    <= dflt_sel ? AW'(DFLT_B) : AW'(DFLT_A);
      af_q    <= dflt_sel ? AW'(DFLT_B) : AW'(DFLT_A);
      mode_q  <= si;
      bit_idx <= '0;
    end else if (prst) begin
      bit_idx <= '0;
    end else if (par_wr) begin
      if (wr_sel == SEL_AE) ae_q <= din[AW-1:0];
      else                  af_q <= din[AW-1:0];
    end else if (sen) begin
      for (int b = 0; b < AW; b++) begin
        if (bit_idx == IW'(b))      ae_q[b] <= si;
        if (bit_idx == IW'(b + AW)) af_q[b] <= si;
      end
      bit_idx <= (bit_idx == LAST) ? '0 : bit_idx + 1'b1;
    end
  end
endmodule

// File: rtl/ofs_readback.sv
`timescale 1ns/1ps
module ofs_readback
  import flag_ofs_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          rd_req,
  input  ofs_sel_e      rd_sel,
  input  logic [AW-1:0] ae_q,
  input  logic [AW-1:0] af_q,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  always_ff @(posedge clk) begin
    if (clr) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= DW'((rd_sel == SEL_AE) ? ae_q : af_q);
    end
  end
endmodule

// File: rtl/flag_ofs_loader.sv
`timescale 1ns/1ps
module flag_ofs_loader
  import flag_ofs_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int DW     = 18,
  parameter int DFLT_A = 7,
  parameter int DFLT_B = 63,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          dflt_sel,
  input  logic          ld,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          ser_en,
  input  logic          ser_in_mode,
  input  logic [DW-1:0] din,
  output logic [AW-1:0] ae_off,
  output logic [AW-1:0] af_off,
  output logic          timing_mode,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  logic     seq_clr;
  logic     par_wr;
  logic     rd_req;
  ofs_sel_e wr_sel;
  ofs_sel_e rd_sel;

  assign seq_clr = mrst | prst;
  assign par_wr  = ld & wr_en;
  assign rd_req  = ld & rd_en & ~seq_clr;

  ofs_seq_ptr u_wr_ptr (
    .clk (wr_clk),
    .clr (seq_clr),
    .adv (par_wr),
    .sel (wr_sel)
  );

  ofs_seq_ptr u_rd_ptr (
    .clk (rd_clk),
    .clr (seq_clr),
    .adv (rd_req),
    .sel (rd_sel)
  );

  ofs_store #(.AW(AW), .DW(DW), .DFLT_A(DFLT_A), .DFLT_B(DFLT_B)) u_store (
    .clk      (wr_clk),
    .mrst     (mrst),
    .prst     (prst),
    .dflt_sel (dflt_sel),
    .par_wr   (par_wr),
    .sen      (ser_en),
    .si       (ser_in_mode),
    .wr_sel   (wr_sel),
    .din      (din),
    .ae_q     (ae_off),
    .af_q     (af_off),
    .mode_q   (timing_mode)
  );

  ofs_readback #(.AW(AW), .DW(DW)) u_rb (
    .clk      (rd_clk),
    .clr      (seq_clr),
    .rd_req   (rd_req),
    .rd_sel   (rd_sel),
    .ae_q     (ae_off),
    .af_q     (af_off),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );
endmodule

// File: rtl/flag_ofs_loader_chk.sv
`timescale 1ns/1ps
module flag_ofs_loader_chk #(
  parameter int AW = 10,
  parameter int DW = 18
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          mrst,
  input logic          prst,
  input logic          ld,
  input logic          wr_en,
  input logic          rd_en,
  input logic          ser_en,
  input logic [DW-1:0] din,
  input logic [AW-1:0] ae_off,
  input logic [AW-1:0] af_off,
  input logic          timing_mode,
  input logic          rd_valid
);
  assert_prst_keeps_R6: assert property (@(posedge wr_clk) disable iff (mrst)
    prst |=> ($stable(ae_off) && $stable(af_off)));

  assert_idle_keeps_R8: assert property (@(posedge wr_clk) disable iff (mrst)
    (!(ld && wr_en) && !ser_en) |=> ($stable(ae_off) && $stable(af_off)));

  assert_par_lands_R3: assert property (@(posedge wr_clk) disable iff (mrst)
    (ld && wr_en && !prst) |=>
      ((ae_off == $past(din[AW-1:0])) || (af_off == $past(din[AW-1:0]))));

  assert_mode_held_R2: assert property (@(posedge wr_clk) disable iff (mrst)
    !mrst |=> $stable(timing_mode));

  assert_rd_follows_R7: assert property (@(posedge rd_clk) disable iff (mrst || prst)
    (ld && rd_en) |=> rd_valid);

  assert_rd_cause_R7: assert property (@(posedge rd_clk) disable iff (mrst)
    rd_valid |-> $past(ld && rd_en));
endmodule

bind flag_ofs_loader flag_ofs_loader_chk #(.AW(AW), .DW(DW)) u_chk (
  .wr_clk      (wr_clk),
  .rd_clk      (rd_clk),
  .mrst        (mrst),
  .prst        (prst),
  .ld          (ld),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .ser_en      (ser_en),
  .din         (din),
  .ae_off      (ae_off),
  .af_off      (af_off),
  .timing_mode (timing_mode),
  .rd_valid    (rd_valid)
);

// File: tb/sim_flag_ofs_loader.sv
`timescale 1ns/1ps
module sim_flag_ofs_loader;
  localparam int DW = 18;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic mrst = 1'b1, prst = 1'b0, dflt_sel = 1'b0;
  logic ld = 1'b0, wr_en = 1'b0, rd_en = 1'b0, ser_en = 1'b0, ser_in_mode = 1'b1;
  logic [DW-1:0] din = '0;
  logic [AW-1:0] ae_off, af_off;
  logic          timing_mode;
  logic [DW-1:0] rd_data;
  logic          rd_valid;

  int n_tests = 0;
  int n_fail  = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #5 clk = ~clk;

  flag_ofs_loader #(.DEPTH(1024), .DW(DW), .DFLT_A(7), .DFLT_B(63)) u0 (
    .wr_clk(clk), .rd_clk(clk), .mrst(mrst), .prst(prst), .dflt_sel(dflt_sel),
    .ld(ld), .wr_en(wr_en), .rd_en(rd_en), .ser_en(ser_en),
    .ser_in_mode(ser_in_mode), .din(din), .ae_off(ae_off), .af_off(af_off),
    .timing_mode(timing_mode), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  // monitor: pops the scoreboard on every read-back result (R7, R8)
  always @(negedge clk) begin
    if (!done && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk("R8 unexpected rd_valid", 1, 0);
      end else begin
        chk("R7 readback data", int'(rd_data), exp_q.pop_front());
      end
    end
  end

  task automatic par_write(input int v);
    ld = 1'b1; wr_en = 1'b1; din = DW'(v);
    @(negedge clk);
    ld = 1'b0; wr_en = 1'b0;
  endtask

  task automatic readback(input int exp);
    exp_q.push_back(exp);
    ld = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    ld = 1'b0; rd_en = 1'b0;
  endtask

  task automatic ser_shift(input int n, input logic [2*AW-1:0] bits);
    for (int i = 0; i < n; i++) begin
      ser_en = 1'b1; ser_in_mode = bits[i];
      @(negedge clk);
    end
    ser_en = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    mrst = 1'b0;
    @(negedge clk);
    chk("R1 ae default A", int'(ae_off), 7);
    chk("R1 af default A", int'(af_off), 7);
    chk("R2 mode captured 1", int'(timing_mode), 1);
    chk("R7 rd_valid idle after reset", int'(rd_valid), 0);

    // R3: parallel writes alternate and wrap
    par_write(100);
    chk("R3 first write to ae", int'(ae_off), 100);
    chk("R3 af untouched", int'(af_off), 7);
    par_write(200);
    chk("R3 second write to af", int'(af_off), 200);
    par_write(300);
    chk("R3 wrap to ae", int'(ae_off), 300);
    chk("R3 af kept", int'(af_off), 200);
    ser_in_mode = 1'b0;
    @(negedge clk);
    chk("R2 mode held after reset", int'(timing_mode), 1);

    // R8: enables without the strobe
    wr_en = 1'b1; din = DW'(777);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
    chk("R8 ae after bare wr_en", int'(ae_off), 300);
    chk("R8 af after bare wr_en", int'(af_off), 200);

    // R7: alternating read-back
    readback(300);
    readback(200);
    readback(300);
    @(negedge clk);

    // R6: partial reset keeps values, restarts sequences
    prst = 1'b1;
    @(negedge clk);
    prst = 1'b0;
    @(negedge clk);
    chk("R6 ae kept over prst", int'(ae_off), 300);
    chk("R6 af kept over prst", int'(af_off), 200);
    readback(300);
    @(negedge clk);

    // R4: serial load, ae LSB first then af
    ser_shift(2 * AW, {10'd682, 10'd341});
    chk("R4 serial ae", int'(ae_off), 341);
    chk("R4 serial af", int'(af_off), 682);

    // R5 + R6: parallel wins; write pointer restarted at ae by prst
    ld = 1'b1; wr_en = 1'b1; ser_en = 1'b1; ser_in_mode = 1'b1; din = DW'(5);
    @(negedge clk);
    ld = 1'b0; wr_en = 1'b0; ser_en = 1'b0;
    chk("R5 parallel beats serial, ae", int'(ae_off), 5);
    chk("R5 af untouched", int'(af_off), 682);
    ser_shift(AW, 20'd9);
    chk("R5 serial index not advanced", int'(ae_off), 9);
    chk("R4 af after partial serial", int'(af_off), 682);

    // R1/R2: second default pair
    mrst = 1'b1; dflt_sel = 1'b1; ser_in_mode = 1'b0;
    repeat (2) @(negedge clk);
    mrst = 1'b0; ser_in_mode = 1'b1;
    @(negedge clk);
    chk("R1 ae default B", int'(ae_off), 63);
    chk("R1 af default B", int'(af_off), 63);
    chk("R2 mode captured 0", int'(timing_mode), 0);
    chk("R7 scoreboard drained", exp_q.size(), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule